// File: doc/BRIEF.md
# Oversampled SPI Slave Transmitter

This block is an SPI slave that runs entirely on its own system clock. The SCK, MOSI and SS pins are not used as clocks. Each one passes through a synchroniser and is sampled on `clk_i`, and SCK edges are found by comparing successive samples. Only mode 0 is handled, with 8-bit frames sent MSB first. MOSI is taken in on SCK rising edges, and MISO moves on SCK falling edges.

A host writes bytes into a small transmit queue, and the serial side drains that queue. The serial side fetches one byte when SS is asserted and another after every eighth bit for as long as SS stays low. If the queue is empty at a fetch, the block sends the last byte it took from the queue again. It does not send zeros. A clear command resets the queue's pointers and flags only. It does not touch the stored data or the byte that gets repeated.

Received bytes come out with a one-cycle strobe. The host sees not-full, empty and sticky overflow status. A masked interrupt combines the not-full, empty and receive strobe flags.

Top module: `spi_os_slave`

## Requirements
- R1: Each transmitted byte leaves MSB first. The first bit is on `miso_o` once SS has been low for a few clocks, before the first SCK rise. Each later bit appears after a detected SCK falling edge.
- R2: MOSI is captured on detected SCK rising edges, MSB first. After the eighth bit, `rx_valid_o` pulses high for exactly one clock with the byte on `rx_data_o`.
- R3: The queue holds 4 entries. A write while it is full is dropped and sets `tx_ovf_o`. That flag stays set until `ovf_clear_i` is pulsed.
- R4: A fetch from the empty queue yields the byte most recently taken from the queue. After reset, that byte is 0x33.
- R5: `tx_clear_i` discards all pending entries and sets the flags to empty and not-full. It leaves the byte repeated on underflow unchanged.
- R6: `tx_not_full_o` is high while fewer than 4 entries are held. `tx_empty_o` is high while none are held.
- R7: `irq_o` is the OR of the flags enabled in `irq_mask_i`. Bit 0 enables not-full, bit 1 enables empty and bit 2 enables the receive strobe.
- R8: `miso_oe_o` is low while SS is high. If SS rises in the middle of a byte, that byte is aborted, no receive strobe is produced, and the next fetch happens at the next SS fall.
- R9: A fetch happens at every SS fall and after every eighth bit, including the last byte of a transaction. An empty fetch does not advance the read position, so a byte written later is the next one sent.
- R10: Reception is correct when each SCK phase lasts a single clock period, which is a bit rate of half `clk_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock, also used to oversample the SPI pins |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sck_i | input | 1 | SPI serial clock from the master (idle low) |
| mosi_i | input | 1 | Serial data from the master |
| ss_ni | input | 1 | Active-low slave select |
| miso_o | output | 1 | Serial data to the master |
| miso_oe_o | output | 1 | Output enable for MISO, high while selected |
| wr_en_i | input | 1 | Host write strobe into the transmit queue |
| wr_data_i | input | 8 | Host write data |
| tx_clear_i | input | 1 | Reset queue pointers and flags, keeping stored data |
| ovf_clear_i | input | 1 | Clears the sticky overflow flag |
| irq_mask_i | input | 3 | Interrupt enables: [0] not-full, [1] empty, [2] receive strobe |
| rx_valid_o | output | 1 | One-clock strobe per received byte |
| rx_data_o | output | 8 | Last received byte |
| tx_not_full_o | output | 1 | Queue can accept a write |
| tx_empty_o | output | 1 | Queue holds no entries |
| tx_ovf_o | output | 1 | Sticky: a write was dropped while full |
| irq_o | output | 1 | Masked interrupt |

## Verification
The assertions check these properties on every cycle:
- the entry count never exceeds the depth;
- a dropped write always leaves the overflow flag set;
- a clear always leaves the queue empty;
- an empty fetch never moves the read position;
- the receive strobe never lasts two cycles;
- the bit counter is reset while deselected.

Some behaviour only the bench scenarios can show:
- which byte actually goes out after an underflow or a clear;
- the MSB-first order on MISO;
- the extra fetch at the end of each transaction;
- correct reception at every MOSI value and at the fastest SCK rate.

// File: rtl/spi_os_pkg.sv
package spi_os_pkg;
  localparam int unsigned BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;

  localparam byte_t FILL_BYTE = 8'h33;

  // interrupt flag positions
  localparam int unsigned IRQ_NOT_FULL = 0;
  localparam int unsigned IRQ_EMPTY    = 1;
  localparam int unsigned IRQ_RX       = 2;
  localparam int unsigned IRQ_W        = 3;
endpackage

// File: rtl/spi_os_sync.sv
module spi_os_sync #(
  parameter int unsigned W      = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o,
  output logic [W-1:0] prev_o
);
  logic [W-1:0] st_q [STAGES];
  logic [W-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q[0] <= RST_VAL;
    else         st_q[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) st_q[s] <= RST_VAL;
      else         st_q[s] <= st_q[s-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= RST_VAL;
    else         prev_q <= st_q[STAGES-1];
  end

  assign q_o    = st_q[STAGES-1];
  assign prev_o = prev_q;
endmodule

// File: rtl/spi_os_txfifo.sv
module spi_os_txfifo
  import spi_os_pkg::*;
#(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned DW    = BYTE_W,
  parameter logic [DW-1:0] RST_BYTE = FILL_BYTE
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          clear_i,
  input  logic          ovf_clear_i,
  input  logic          pop_i,
  output logic [DW-1:0] pop_data_o,
  output logic          empty_o,
  output logic          full_o,
  output logic          ovf_o
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);

  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] rd_q, wr_q;
  logic [CW-1:0] cnt_q;
  logic [DW-1:0] last_q;
  logic          ovf_q;
  logic          do_wr, do_pop;

  function automatic logic [AW-1:0] next_idx(input logic [AW-1:0] idx);
    return (idx == LAST_IDX) ? '0 : idx + AW'(1);
  endfunction

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CW'(DEPTH));
  assign do_wr   = wr_en_i && !full_o && !clear_i;
  assign do_pop  = pop_i && !empty_o && !clear_i;

  // empty queue returns the byte last taken from storage
  assign pop_data_o = empty_o ? last_q : mem_q[rd_q];

  // storage is never cleared by clear_i
  for (genvar i = 0; i < DEPTH; i++) begin : g_mem
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                        mem_q[i] <= RST_BYTE;
      else if (do_wr && wr_q == AW'(i))   mem_q[i] <= wr_data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else if (clear_i) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_wr)  wr_q <= next_idx(wr_q);
      if (do_pop) rd_q <= next_idx(rd_q);
      cnt_q <= cnt_q + CW'(do_wr) - CW'(do_pop);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   last_q <= RST_BYTE;
    else if (pop_i && !empty_o)    last_q <= mem_q[rd_q];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                 ovf_q <= 1'b0;
    else if (ovf_clear_i)                        ovf_q <= 1'b0;
    else if (wr_en_i && full_o && !clear_i)      ovf_q <= 1'b1;
  end

  assign ovf_o = ovf_q;

  always_ff @(posedge clk_i) begin
    if (rst_ni) p_no_overflow_r3: assert (cnt_q <= CW'(DEPTH));
  end

  p_drop_sets_ovf_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && full_o && !clear_i && !ovf_clear_i) |=> ovf_o);

  p_clear_empties_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> empty_o);

  p_empty_pop_holds_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && empty_o && !clear_i) |=> $stable(rd_q));

  p_empty_pop_keeps_byte_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && empty_o) |=> $stable(last_q));
endmodule

// File: rtl/spi_os_shifter.sv
module spi_os_shifter
  import spi_os_pkg::*;
#(
  parameter int unsigned DW = BYTE_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          active_i,
  input  logic          ss_fall_i,
  input  logic          sck_rise_i,
  input  logic          sck_fall_i,
  input  logic          mosi_i,
  input  logic [DW-1:0] fetch_data_i,
  output logic          fetch_o,
  output logic          miso_o,
  output logic          rx_valid_o,
  output logic [DW-1:0] rx_data_o
);
  localparam int unsigned BW = (DW > 1) ? $clog2(DW) : 1;
  localparam logic [BW-1:0] LAST_BIT = BW'(DW - 1);

  logic [DW-1:0] tx_sr_q, rx_sr_q, rx_data_q;
  logic [BW-1:0] bit_cnt_q;
  logic          reload_q, rx_valid_q;

  // reload_q marks a completed byte; next fetch goes with the falling edge
  assign fetch_o = ss_fall_i || (active_i && sck_fall_i && reload_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_sr_q    <= '0;
      rx_sr_q    <= '0;
      rx_data_q  <= '0;
      bit_cnt_q  <= '0;
      reload_q   <= 1'b0;
      rx_valid_q <= 1'b0;
    end else begin
      rx_valid_q <= 1'b0;
      if (!active_i) begin
        bit_cnt_q <= '0;
        reload_q  <= 1'b0;
      end else if (ss_fall_i) begin
        tx_sr_q   <= fetch_data_i;
        bit_cnt_q <= '0;
        reload_q  <= 1'b0;
      end else begin
        if (sck_rise_i) begin
          rx_sr_q <= {rx_sr_q[DW-2:0], mosi_i};
          if (bit_cnt_q == LAST_BIT) begin
            rx_data_q  <= {rx_sr_q[DW-2:0], mosi_i};
            rx_valid_q <= 1'b1;
            bit_cnt_q  <= '0;
            reload_q   <= 1'b1;
          end else begin
            bit_cnt_q <= bit_cnt_q + BW'(1);
          end
        end
        if (sck_fall_i) begin
          if (reload_q) begin
            tx_sr_q  <= fetch_data_i;
            reload_q <= 1'b0;
          end else begin
            tx_sr_q <= {tx_sr_q[DW-2:0], 1'b0};
          end
        end
      end
    end
  end

  assign miso_o     = tx_sr_q[DW-1];
  assign rx_valid_o = rx_valid_q;
  assign rx_data_o  = rx_data_q;

  p_rx_single_pulse_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |=> !rx_valid_o);

  p_idle_cnt_reset_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_i |=> (bit_cnt_q == '0) && !reload_q);

  p_no_rx_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_i |=> !rx_valid_o);
endmodule

// File: rtl/spi_os_slave.sv
module spi_os_slave
  import spi_os_pkg::*;
#(
  parameter int unsigned DW          = BYTE_W,
  parameter int unsigned DEPTH       = 4,
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic [DW-1:0] RST_BYTE  = FILL_BYTE
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sck_i,
  input  logic          mosi_i,
  input  logic          ss_ni,
  output logic          miso_o,
  output logic          miso_oe_o,
  input  logic          wr_en_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          tx_clear_i,
  input  logic          ovf_clear_i,
  input  logic [IRQ_W-1:0] irq_mask_i,
  output logic          rx_valid_o,
  output logic [DW-1:0] rx_data_o,
  output logic          tx_not_full_o,
  output logic          tx_empty_o,
  output logic          tx_ovf_o,
  output logic          irq_o
);
  localparam int unsigned PIN_SCK  = 0;
  localparam int unsigned PIN_MOSI = 1;
  localparam int unsigned PIN_SS   = 2;
  localparam int unsigned PINS     = 3;
  localparam logic [PINS-1:0] PIN_RST = 3'b100;  // SS idles high

  logic [PINS-1:0] pin_q, pin_prev;
  logic            active, ss_fall, sck_rise, sck_fall;
  logic            fetch;
  logic [DW-1:0]   fetch_data;
  logic            q_empty, q_full;
  logic [IRQ_W-1:0] flags;

  spi_os_sync #(
    .W      (PINS),
    .STAGES (SYNC_STAGES),
    .RST_VAL(PIN_RST)
  ) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({ss_ni, mosi_i, sck_i}),
    .q_o   (pin_q),
    .prev_o(pin_prev)
  );

  assign active   = !pin_q[PIN_SS];
  assign ss_fall  = pin_prev[PIN_SS] && !pin_q[PIN_SS];
  assign sck_rise = active && !pin_prev[PIN_SCK] && pin_q[PIN_SCK];
  assign sck_fall = active && pin_prev[PIN_SCK] && !pin_q[PIN_SCK];

  spi_os_txfifo #(
    .DEPTH   (DEPTH),
    .DW      (DW),
    .RST_BYTE(RST_BYTE)
  ) u_fifo (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .wr_data_i  (wr_data_i),
    .clear_i    (tx_clear_i),
    .ovf_clear_i(ovf_clear_i),
    .pop_i      (fetch),
    .pop_data_o (fetch_data),
    .empty_o    (q_empty),
    .full_o     (q_full),
    .ovf_o      (tx_ovf_o)
  );

  spi_os_shifter #(
    .DW(DW)
  ) u_shift (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .active_i    (active),
    .ss_fall_i   (ss_fall),
    .sck_rise_i  (sck_rise),
    .sck_fall_i  (sck_fall),
    .mosi_i      (pin_q[PIN_MOSI]),
    .fetch_data_i(fetch_data),
    .fetch_o     (fetch),
    .miso_o      (miso_o),
    .rx_valid_o  (rx_valid_o),
    .rx_data_o   (rx_data_o)
  );

  assign miso_oe_o     = active;
  assign tx_empty_o    = q_empty;
  assign tx_not_full_o = !q_full;

  always_comb begin
    flags               = '0;
    flags[IRQ_NOT_FULL] = !q_full;
    flags[IRQ_EMPTY]    = q_empty;
    flags[IRQ_RX]       = rx_valid_o;
  end
  assign irq_o = |(flags & irq_mask_i);

  p_rx_needs_select_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |-> $past(miso_oe_o));

  p_flags_exclusive_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(tx_empty_o && !tx_not_full_o));

  p_masked_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_mask_i == '0) |-> !irq_o);
endmodule

// File: tb/spi_os_slave_tb_top.sv
module spi_os_slave_tb_top;
  typedef logic [7:0] byte_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck = 1'b0, mosi = 1'b0, ss_n = 1'b1;
  logic wr_en = 1'b0, tx_clear = 1'b0, ovf_clear = 1'b0;
  byte_t wr_data = '0;
  logic [2:0] irq_mask = '0;
  logic miso, miso_oe, rx_valid, tx_not_full, tx_empty, tx_ovf, irq;
  byte_t rx_data;

  always #10 clk = ~clk;

  spi_os_slave dut_i (
    .clk_i(clk), .rst_ni(rst_n), .sck_i(sck), .mosi_i(mosi), .ss_ni(ss_n),
    .miso_o(miso), .miso_oe_o(miso_oe), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .tx_clear_i(tx_clear), .ovf_clear_i(ovf_clear), .irq_mask_i(irq_mask),
    .rx_valid_o(rx_valid), .rx_data_o(rx_data), .tx_not_full_o(tx_not_full),
    .tx_empty_o(tx_empty), .tx_ovf_o(tx_ovf), .irq_o(irq)
  );

  int n_tests = 0, n_fail = 0;
  int rx_cnt = 0, irq_cnt = 0;
  byte_t rx_last = '0;
  byte_t mq[$];
  byte_t mlast = 8'h33;

  always @(posedge clk) begin
    if (rx_valid) begin rx_cnt++; rx_last = rx_data; end
    if (irq) irq_cnt++;
  end

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic m_fetch();
    if (mq.size() > 0) mlast = mq.pop_front();
  endtask

  task automatic host_write(input byte_t b);
    @(negedge clk); wr_en = 1'b1; wr_data = b;
    @(negedge clk); wr_en = 1'b0;
    if (mq.size() < 4) mq.push_back(b);
  endtask

  task automatic host_clear();
    @(negedge clk); tx_clear = 1'b1;
    @(negedge clk); tx_clear = 1'b0;
    mq.delete();
  endtask

  task automatic xfer(input byte_t mo, input int ph, output byte_t mi);
    for (int i = 7; i >= 0; i--) begin
      sck = 1'b0; mosi = mo[i];
      repeat (ph) @(negedge clk);
      mi[i] = miso;
      sck = 1'b1;
      repeat (ph) @(negedge clk);
    end
  endtask

  // n bytes in one SS window; MISO compared with model, MOSI with rx output
  task automatic txn(input int n, input int ph, input byte_t base, input bit chk_tx,
                     input bit chk_rx, input string req);
    byte_t got, exp, mo;
    int rx0;
    @(negedge clk); ss_n = 1'b0;
    m_fetch();
    repeat (6) @(negedge clk);
    for (int k = 0; k < n; k++) begin
      mo = base + byte_t'(k);
      exp = mlast;
      rx0 = rx_cnt;
      xfer(mo, ph, got);
      repeat (4) @(negedge clk);
      if (chk_tx) chk(req, got, exp);
      if (chk_rx) begin
        chk({req, " rx data"}, rx_last, mo);
        chk({req, " rx pulses"}, rx_cnt - rx0, 1);
      end
      m_fetch();
    end
    sck = 1'b0;
    repeat (ph + 4) @(negedge clk);
    ss_n = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    byte_t got;
    int rx0, irq0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // reset state
    chk("R6 empty after reset", tx_empty, 1);
    chk("R6 not full after reset", tx_not_full, 1);
    chk("R3 ovf after reset", tx_ovf, 0);
    chk("R8 oe while deselected", miso_oe, 0);
    chk("R7 irq masked", irq, 0);

    // R4: underflow straight after reset repeats 0x33
    txn(2, 5, 8'h00, 1, 0, "R4 reset fill byte");

    // R3 / R6: fill, overflow, drop
    for (int j = 0; j < 4; j++) host_write(8'hA1 + byte_t'(j * 17));
    chk("R6 full not_full", tx_not_full, 0);
    chk("R6 full empty", tx_empty, 0);
    host_write(8'hEE);
    chk("R3 ovf set on drop", tx_ovf, 1);
    repeat (3) @(negedge clk);
    chk("R3 ovf sticky", tx_ovf, 1);
    txn(4, 5, 8'h10, 1, 1, "R1 R9 four byte frame");
    chk("R3 ovf still set", tx_ovf, 1);
    @(negedge clk); ovf_clear = 1'b1;
    @(negedge clk); ovf_clear = 1'b0;
    chk("R3 ovf cleared", tx_ovf, 0);
    txn(1, 5, 8'h20, 1, 0, "R4 repeat last byte");

    // R5: clear keeps the repeated byte, drops pending entries
    host_write(8'h5A); host_write(8'h6B);
    host_clear();
    chk("R5 empty after clear", tx_empty, 1);
    chk("R5 not full after clear", tx_not_full, 1);
    txn(2, 5, 8'h30, 1, 0, "R5 repeat after clear");

    // R9: empty fetch did not move the read side; new write goes out next
    host_write(8'h77);
    txn(2, 5, 8'h40, 1, 0, "R9 write after underflow");

    // R1 R6 R9: sweep fill levels 0..4 then a five byte frame
    for (int f = 0; f <= 4; f++) begin
      for (int j = 0; j < f; j++) host_write(byte_t'(f * 16 + j * 3 + 1));
      chk("R6 empty by level", tx_empty, (f == 0) ? 1 : 0);
      chk("R6 not_full by level", tx_not_full, (f < 4) ? 1 : 0);
      txn(5, 5, byte_t'(f * 40), 1, 0, "R9 fill sweep");
    end

    // R8: abort mid-byte
    host_write(8'h3C); host_write(8'h9F);
    rx0 = rx_cnt;
    @(negedge clk); ss_n = 1'b0; m_fetch();
    repeat (6) @(negedge clk);
    chk("R8 oe while selected", miso_oe, 1);
    for (int i = 7; i >= 5; i--) begin
      sck = 1'b0; mosi = 1'b1;
      repeat (5) @(negedge clk);
      chk("R1 msb first partial", miso, (8'h3C >> i) & 1);
      sck = 1'b1;
      repeat (5) @(negedge clk);
    end
    sck = 1'b0;
    repeat (5) @(negedge clk);
    ss_n = 1'b1;
    repeat (6) @(negedge clk);
    chk("R8 oe low after abort", miso_oe, 0);
    chk("R8 no rx on abort", rx_cnt - rx0, 0);
    txn(1, 5, 8'h00, 1, 1, "R8 fresh fetch after abort");

    // R2: every MOSI value in one long frame
    txn(256, 5, 8'h00, 0, 1, "R2 rx sweep");

    // R10: one clock per SCK phase
    txn(2, 1, 8'hC5, 0, 1, "R10 fast rx");

    // R7: mask sweep while empty and not full
    for (int m = 0; m < 8; m++) begin
      @(negedge clk); irq_mask = 3'(m);
      @(negedge clk);
      chk("R7 irq empty state", irq, ((m & 3) != 0) ? 1 : 0);
    end
    for (int j = 0; j < 4; j++) host_write(byte_t'(j));
    for (int m = 0; m < 8; m++) begin
      @(negedge clk); irq_mask = 3'(m);
      @(negedge clk);
      chk("R7 irq full state", irq, 0);
    end
    host_clear();
    host_write(8'h01);
    for (int m = 0; m < 8; m++) begin
      @(negedge clk); irq_mask = 3'(m);
      @(negedge clk);
      chk("R7 irq partial state", irq, m & 1);
    end
    host_clear();
    @(negedge clk); irq_mask = 3'b100;
    irq0 = irq_cnt; rx0 = rx_cnt;
    txn(3, 5, 8'h55, 0, 1, "R7 rx irq frame");
    chk("R7 irq pulses equal rx", irq_cnt - irq0, 3);
    chk("R2 pulse count", rx_cnt - rx0, 3);

    summary();
  end
endmodule